// File: doc/BRIEF.md
# Low-Power DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a low-power DDR SDRAM and takes the memory from a freshly powered, unconfigured state to one where it accepts ordinary traffic. After reset it keeps the clock-enable pin low and the command bus idle. A single start strobe then raises clock enable, holds a long stabilization wait, and issues a fixed series of commands with idle gaps between them: a precharge of every bank, two auto-refresh cycles, a load of the standard mode register, and a load of the extended mode register that carries the partial-array self-refresh field.

Every wait is a parameter counted in clock cycles, and one shared down-counter times all of them. The two mode-register values are taken from input ports at the moment of the start strobe. A ready flag rises once the last gap has elapsed and then stays high until reset. No step resets or enables a delay-locked loop. A parameter selects whether the memory pins come straight from the state decode or from an output register stage.

Top module: `lpinit_seq`

## Requirements
- R1: While reset is held, and afterwards until a start strobe is sampled, cke_o is low, ready_o is low, ba_o and addr_o are zero and the command pins carry NOP.
- R2: Command pins {cs_n_o, ras_n_o, cas_n_o, we_n_o} use 4'b0111 for NOP, 4'b0010 for PRECHARGE, 4'b0001 for AUTO REFRESH and 4'b0000 for LOAD MODE REGISTER. No other code appears.
- R3: The cycle after start is sampled, cke_o goes high with REG_OUT=1, or in that same cycle with REG_OUT=0. It then stays high until reset.
- R4: Exactly T_STABLE NOP cycles with cke_o high pass before the first command. With REG_OUT=1, the first command appears T_STABLE+1 cycles after the edge that samples start.
- R5: The first command is PRECHARGE with addr_o[10] high, which selects all banks, and ba_o = 0. It is followed by exactly T_RP NOP cycles.
- R6: Exactly two AUTO REFRESH commands follow the precharge gap. Each lasts one cycle and is followed by exactly T_RFC NOP cycles.
- R7: After the second refresh gap comes LOAD MODE REGISTER with ba_o = 2'b00 and addr_o set to the standard mode value, followed by exactly T_MRD NOP cycles.
- R8: Next comes LOAD MODE REGISTER with ba_o = 2'b10 and addr_o set to the extended mode value, again followed by exactly T_MRD NOP cycles.
- R9: ready_o rises in the first cycle after the final T_MRD gap. It then stays high, with NOP on the bus, until reset.
- R10: A start strobe is ignored while the sequence runs or after ready. Both mode values are captured at the accepted strobe, so later changes on mode_i or ext_mode_i have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only while idle |
| mode_i | input | ADDR_W | Standard mode register value (CAS latency, burst length) |
| ext_mode_i | input | ADDR_W | Extended mode register value (partial-array self-refresh field) |
| cke_o | output | 1 | Clock enable to memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address lines |
| ready_o | output | 1 | Initialization complete, sticky until reset |

## Verification
The assertions assume every timing parameter is at least one cycle. Under that assumption no two commands can sit on adjacent cycles, and each refresh gap separates the commands around it. They also assume that reset is the only way back to idle, which is what makes the refresh count and the ready flag monotonic. The bench keeps to these assumptions: it uses small gap values, all of them one cycle or longer, and it returns the block to idle only through reset. Start strobes and changes to the mode inputs land in the middle of the sequence and after ready, so the assertions see these disturbances without any forbidden input.

// File: rtl/lpinit_pkg.sv
package lpinit_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_NOP = 4'b0111,
      CMD_PRE = 4'b0010,
      CMD_REF = 4'b0001,
      CMD_LMR = 4'b0000
   } cmd_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_STABLE,
      ST_PRE,
      ST_GAP_RP,
      ST_REF1,
      ST_GAP_RFC1,
      ST_REF2,
      ST_GAP_RFC2,
      ST_MRS,
      ST_GAP_MRD1,
      ST_EMRS,
      ST_GAP_MRD2,
      ST_DONE
   } state_e;

endpackage

// File: rtl/lpinit_timer.sv
module lpinit_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             zero_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/lpinit_fsm.sv
module lpinit_fsm
   import lpinit_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int CNT_W    = 16,
   parameter int T_STABLE = 20000,
   parameter int T_RP     = 3,
   parameter int T_RFC    = 8,
   parameter int T_MRD    = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] mode_i,
   input  logic [ADDR_W-1:0] ext_mode_i,
   input  logic              zero_i,
   output logic              load_o,
   output logic [CNT_W-1:0]  load_val_o,
   output state_e            state_o,
   output logic [ADDR_W-1:0] mode_q_o,
   output logic [ADDR_W-1:0] ext_q_o
);

   state_e            state_q, state_d;
   logic [ADDR_W-1:0] mode_q, ext_q;

   function automatic state_e succ(state_e s);
      case (s)
         ST_STABLE:   return ST_PRE;
         ST_PRE:      return ST_GAP_RP;
         ST_GAP_RP:   return ST_REF1;
         ST_REF1:     return ST_GAP_RFC1;
         ST_GAP_RFC1: return ST_REF2;
         ST_REF2:     return ST_GAP_RFC2;
         ST_GAP_RFC2: return ST_MRS;
         ST_MRS:      return ST_GAP_MRD1;
         ST_GAP_MRD1: return ST_EMRS;
         ST_EMRS:     return ST_GAP_MRD2;
         default:     return ST_DONE;
      endcase
   endfunction

   // counter reload = residence time minus one
   function automatic logic [CNT_W-1:0] hold(state_e s);
      case (s)
         ST_STABLE:                return CNT_W'(T_STABLE - 1);
         ST_GAP_RP:                return CNT_W'(T_RP - 1);
         ST_GAP_RFC1, ST_GAP_RFC2: return CNT_W'(T_RFC - 1);
         ST_GAP_MRD1, ST_GAP_MRD2: return CNT_W'(T_MRD - 1);
         default:                  return '0;
      endcase
   endfunction

   always_comb begin
      state_d    = state_q;
      load_o     = 1'b0;
      load_val_o = '0;
      case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               state_d    = ST_STABLE;
               load_o     = 1'b1;
               load_val_o = hold(ST_STABLE);
            end
         end
         ST_DONE: state_d = ST_DONE;
         default: begin
            if (zero_i) begin
               state_d    = succ(state_q);
               load_o     = 1'b1;
               load_val_o = hold(succ(state_q));
            end
         end
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         mode_q  <= '0;
         ext_q   <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && start_i) begin
            mode_q <= mode_i;
            ext_q  <= ext_mode_i;
         end
      end
   end

   assign state_o  = state_q;
   assign mode_q_o = mode_q;
   assign ext_q_o  = ext_q;

endmodule

// File: rtl/lpinit_pins.sv
module lpinit_pins
   import lpinit_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int BA_W    = 2,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  state_e            state_i,
   input  logic [ADDR_W-1:0] mode_q_i,
   input  logic [ADDR_W-1:0] ext_q_i,
   output logic              cke_o,
   output logic [3:0]        cmd_o,
   output logic [BA_W-1:0]   ba_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              ready_o
);

   localparam logic [BA_W-1:0] BA_STD = '0;
   localparam logic [BA_W-1:0] BA_EXT = BA_W'(2);
   localparam int              A_ALL  = 10;

   logic              cke_d, rdy_d;
   cmd_e              cmd_d;
   logic [BA_W-1:0]   ba_d;
   logic [ADDR_W-1:0] addr_d;

   always_comb begin
      cke_d  = (state_i != ST_IDLE);
      rdy_d  = (state_i == ST_DONE);
      cmd_d  = CMD_NOP;
      ba_d   = '0;
      addr_d = '0;
      case (state_i)
         ST_PRE: begin
            cmd_d         = CMD_PRE;
            addr_d[A_ALL] = 1'b1;
         end
         ST_REF1, ST_REF2: cmd_d = CMD_REF;
         ST_MRS: begin
            cmd_d  = CMD_LMR;
            ba_d   = BA_STD;
            addr_d = mode_q_i;
         end
         ST_EMRS: begin
            cmd_d  = CMD_LMR;
            ba_d   = BA_EXT;
            addr_d = ext_q_i;
         end
         default: ;
      endcase
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            cke_o   <= 1'b0;
            cmd_o   <= CMD_NOP;
            ba_o    <= '0;
            addr_o  <= '0;
            ready_o <= 1'b0;
         end else begin
            cke_o   <= cke_d;
            cmd_o   <= cmd_d;
            ba_o    <= ba_d;
            addr_o  <= addr_d;
            ready_o <= rdy_d;
         end
      end
   end else begin : g_comb
      assign cke_o   = cke_d;
      assign cmd_o   = cmd_d;
      assign ba_o    = ba_d;
      assign addr_o  = addr_d;
      assign ready_o = rdy_d;
   end

endmodule

// File: rtl/lpinit_seq.sv
module lpinit_seq
   import lpinit_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int BA_W     = 2,
   parameter int T_STABLE = 20000,
   parameter int T_RP     = 3,
   parameter int T_RFC    = 8,
   parameter int T_MRD    = 2,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] mode_i,
   input  logic [ADDR_W-1:0] ext_mode_i,
   output logic              cke_o,
   output logic              cs_n_o,
   output logic              ras_n_o,
   output logic              cas_n_o,
   output logic              we_n_o,
   output logic [BA_W-1:0]   ba_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              ready_o
);

   localparam int MAX_GAP = (T_RFC > T_RP) ? ((T_RFC > T_MRD) ? T_RFC : T_MRD)
                                           : ((T_RP  > T_MRD) ? T_RP  : T_MRD);
   localparam int MAX_T   = (T_STABLE > MAX_GAP) ? T_STABLE : MAX_GAP;
   localparam int CNT_W   = $clog2(MAX_T + 1);

   if (ADDR_W < 11) begin : g_bad_addr
      $error("lpinit_seq: ADDR_W must reach the all-bank bit");
   end
   if (BA_W != 2) begin : g_bad_ba
      $error("lpinit_seq: BA_W must be 2");
   end
   if (T_STABLE < 1 || T_RP < 1 || T_RFC < 1 || T_MRD < 1) begin : g_bad_t
      $error("lpinit_seq: every timing parameter must be at least 1");
   end

   logic              load, zero;
   logic [CNT_W-1:0]  load_val;
   state_e            state;
   logic [ADDR_W-1:0] mode_q, ext_q;
   logic [3:0]        cmd;

   lpinit_timer #(.CNT_W(CNT_W)) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load),
      .load_val_i (load_val),
      .zero_o     (zero)
   );

   lpinit_fsm #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .T_STABLE(T_STABLE),
      .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD)
   ) u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start_i),
      .mode_i     (mode_i),
      .ext_mode_i (ext_mode_i),
      .zero_i     (zero),
      .load_o     (load),
      .load_val_o (load_val),
      .state_o    (state),
      .mode_q_o   (mode_q),
      .ext_q_o    (ext_q)
   );

   lpinit_pins #(.ADDR_W(ADDR_W), .BA_W(BA_W), .REG_OUT(REG_OUT)) u_pins (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .state_i  (state),
      .mode_q_i (mode_q),
      .ext_q_i  (ext_q),
      .cke_o    (cke_o),
      .cmd_o    (cmd),
      .ba_o     (ba_o),
      .addr_o   (addr_o),
      .ready_o  (ready_o)
   );

   assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;

endmodule

// File: rtl/lpinit_seq_chk.sv
module lpinit_seq_chk #(
   parameter int ADDR_W = 12,
   parameter int BA_W   = 2
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              cke_o,
   input logic              cs_n_o,
   input logic              ras_n_o,
   input logic              cas_n_o,
   input logic              we_n_o,
   input logic [BA_W-1:0]   ba_o,
   input logic [ADDR_W-1:0] addr_o,
   input logic              ready_o
);

   logic [3:0] cmd;
   logic [1:0] ref_seen;
   assign cmd = {cs_n_o, ras_n_o, cas_n_o, we_n_o};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             ref_seen <= '0;
      else if (cmd == 4'b0001 && ref_seen != 2'd3) ref_seen <= ref_seen + 1'b1;
   end

   AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cke_o |-> (cmd == 4'b0111 && !ready_o));                               // R1
   AST_LEGAL_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd inside {4'b0111, 4'b0010, 4'b0001, 4'b0000});                       // R2
   AST_CKE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cke_o |=> cke_o);                                                       // R3
   AST_PRE_ALL_BANKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd == 4'b0010 |-> addr_o[10]);                                         // R5
   AST_CMD_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd != 4'b0111 |=> cmd == 4'b0111);                                     // R6
   AST_TWO_REFRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd == 4'b0000 |-> ref_seen == 2'd2);                                   // R7
   AST_LMR_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd == 4'b0000 |-> (ba_o == 2'b00 || ba_o == 2'b10));                   // R8
   AST_READY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_o |=> ready_o);                                                   // R9
   AST_READY_BUS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_o |-> (cmd == 4'b0111 && cke_o));                                 // R9

endmodule

bind lpinit_seq lpinit_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .cke_o   (cke_o),
   .cs_n_o  (cs_n_o),
   .ras_n_o (ras_n_o),
   .cas_n_o (cas_n_o),
   .we_n_o  (we_n_o),
   .ba_o    (ba_o),
   .addr_o  (addr_o),
   .ready_o (ready_o)
);

// File: tb/lpinit_seq_tb.sv
module lpinit_seq_tb;

   localparam int ADDR_W = 12;
   localparam int BA_W   = 2;
   localparam int TS     = 40;
   localparam int TRP    = 3;
   localparam int TRFC   = 6;
   localparam int TMRD   = 2;
   localparam int LAT    = 1;
   // j index (cycles after the sampling edge, state time) of each command
   localparam int B_PRE  = TS;
   localparam int B_REF1 = B_PRE + 1 + TRP;
   localparam int B_REF2 = B_REF1 + 1 + TRFC;
   localparam int B_MRS  = B_REF2 + 1 + TRFC;
   localparam int B_EMRS = B_MRS + 1 + TMRD;
   localparam int B_RDY  = B_EMRS + 1 + TMRD;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [ADDR_W-1:0] mode = '0, ext = '0;
   logic              cke, cs_n, ras_n, cas_n, we_n, ready;
   logic [BA_W-1:0]   ba;
   logic [ADDR_W-1:0] addr;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   always #5 clk = ~clk;

   lpinit_seq #(
      .ADDR_W(ADDR_W), .BA_W(BA_W), .T_STABLE(TS), .T_RP(TRP),
      .T_RFC(TRFC), .T_MRD(TMRD), .REG_OUT(1'b1)
   ) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
      .ext_mode_i(ext), .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n),
      .cas_n_o(cas_n), .we_n_o(we_n), .ba_o(ba), .addr_o(addr), .ready_o(ready)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   function automatic logic [3:0] pins_cmd();
      return {cs_n, ras_n, cas_n, we_n};
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      start = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // R1: idle before start
   task automatic t_reset_state();
      do_reset();
      repeat (6) @(negedge clk);
      chk("R1 cke", cke, 0);
      chk("R1 cmd", pins_cmd(), 4'b0111);
      chk("R1 ready", ready, 0);
      chk("R1 addr", addr, 0);
      chk("R1 ba", ba, 0);
   endtask

   // full sequence; disturb pulses start and alters mode inputs mid-run
   task automatic t_sequence(logic [ADDR_W-1:0] m, logic [ADDR_W-1:0] e, bit disturb);
      int pre_cnt = 0;
      logic [3:0] exp_cmd;
      do_reset();
      mode  = m;
      ext   = e;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i <= B_RDY + LAT + 4; i++) begin
         int j = i - LAT;
         exp_cmd = 4'b0111;
         if (j == B_PRE) exp_cmd = 4'b0010;
         else if (j == B_REF1 || j == B_REF2) exp_cmd = 4'b0001;
         else if (j == B_MRS || j == B_EMRS) exp_cmd = 4'b0000;
         chk("R3 cke", cke, (j >= 0) ? 1 : 0);
         if (exp_cmd != 4'b0111)
            chk("R2 cmd code", pins_cmd(), exp_cmd);
         else if (j < B_PRE)
            chk("R4 stable NOP", pins_cmd(), exp_cmd);
         else if (j < B_REF1)
            chk("R5 tRP gap", pins_cmd(), exp_cmd);
         else if (j < B_MRS)
            chk("R6 tRFC gap", pins_cmd(), exp_cmd);
         else if (j < B_RDY)
            chk("R7 tMRD gap", pins_cmd(), exp_cmd);
         else
            chk("R9 bus idle", pins_cmd(), exp_cmd);
         if (j == B_PRE) begin
            chk("R5 A10", addr[10], 1);
            chk("R5 ba", ba, 0);
         end
         if (j == B_MRS) begin
            chk("R7 ba", ba, 2'b00);
            chk(disturb ? "R10 mode kept" : "R7 addr", addr, m);
         end
         if (j == B_EMRS) begin
            chk("R8 ba", ba, 2'b10);
            chk(disturb ? "R10 ext kept" : "R8 addr", addr, e);
         end
         chk("R9 ready", ready, (j >= B_RDY) ? 1 : 0);
         if (pins_cmd() == 4'b0010) pre_cnt++;
         if (disturb && (i == 5 || i == B_PRE + 2 || i == B_RDY + 2)) begin
            start = 1'b1;
            mode  = ~m;
            ext   = ~e;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      chk("R10 single precharge", pre_cnt, 1);
   endtask

   // R9/R10: ready sticks, start after ready does nothing
   task automatic t_after_ready();
      bit bad = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 20; k++) begin
         if (!ready || !cke || pins_cmd() != 4'b0111) bad = 1;
         @(negedge clk);
      end
      chk("R10 start after ready ignored", bad, 0);
   endtask

   // R1: reset mid-sequence returns to idle and stays there
   task automatic t_mid_reset();
      do_reset();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (TS + 4) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 reset cke", cke, 0);
      chk("R1 reset ready", ready, 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      chk("R1 idle cke", cke, 0);
      chk("R1 idle cmd", pins_cmd(), 4'b0111);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 50000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      t_reset_state();
      t_sequence(12'h032, 12'h001, 1'b0);
      t_after_ready();
      t_sequence(12'h5A3, 12'hC47, 1'b1);
      t_mid_reset();
      t_sequence(12'hFFF, 12'h000, 1'b0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule